// File: doc/BRIEF.md
# Memory Boundary-Scan Mode Sequencer

This block sits on the controller side of a graphics SDRAM and takes the device through power-up, into boundary-scan mode, back out of it, and through re-initialization. It drives the device's reset, clock-enable and scan-enable levels. It times the reset-low interval with an external 1 µs tick and times the post-reset settling with controller clock cycles. After scan exit it sends precharge-all, extended-mode-set and mode-set commands as single-cycle strobes. These commands restore termination and mode settings, because scan entry wipes them.

A configuration input chooses one of two start-up paths. In the normal path, the command/address termination is enabled by a full reset phase before scan can be entered. In the stand-alone path, that phase is skipped and scan is accepted right after the supply is reported stable. Every scan exit is followed by the same re-initialization, whichever path was taken. All outputs come straight from flip-flops.

Top module: `mbs_sequencer`

## Requirements
- R1: After reset, res_o, cke_o, sen_o and cmd_vld_o are 0, cmd_op_o is 0 and status_o reads idle (0).
- R2: In normal mode (standalone=0), once supply_ok is seen, res_o stays low until at least US_WAIT us_tick pulses have been counted in the resetting state.
- R3: cke_o rises exactly CKE_SETUP cycles before every rising edge of res_o, and cke_o stays high for as long as res_o is high.
- R4: After the initial rise of res_o, status_o changes to ready (4) exactly CLK_WAIT cycles later, and no command is issued.
- R5: A one-cycle scan_req in the idle or ready state drives sen_o high on the next cycle, drives res_o low and sets status_o to in-scan (2).
- R6: scan_req has no effect in any state other than idle or ready. sen_o stays low and status_o is unchanged.
- R7: A scan_done pulse during scan drops sen_o on the next cycle. res_o then rises exactly TSN_WAIT + CKE_SETUP cycles after sen_o fell.
- R8: CLK_WAIT cycles after the post-scan rise of res_o, three one-cycle strobes appear on cmd_vld_o, spaced CMD_GAP cycles apart. Their cmd_op_o values are precharge-all (1), then extended mode set (2), then mode set (3). cmd_op_o is 0 when there is no strobe.
- R9: status_o reads re-initializing (3) from scan exit through the command phase. It changes to ready exactly CMD_GAP cycles after the mode-set strobe.
- R10: In stand-alone mode (standalone=1 while supply_ok rises), res_o stays low and status_o stays idle, and a scan_req enters scan at once.
- R11: status_o only ever takes the values 0 to 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst | input | 1 | Synchronous active-high reset |
| supply_ok | input | 1 | Supplies and reference are stable |
| standalone | input | 1 | Skip the pre-scan reset phase; sampled when supply_ok is first seen |
| scan_req | input | 1 | Request entry into boundary-scan mode |
| scan_done | input | 1 | Request exit from boundary-scan mode |
| us_tick | input | 1 | One-cycle pulse every microsecond |
| res_o | output | 1 | Device reset level (low = reset) |
| cke_o | output | 1 | Device clock-enable level |
| sen_o | output | 1 | Device scan-enable level |
| cmd_vld_o | output | 1 | One-cycle command strobe |
| cmd_op_o | output | 2 | Command opcode: 0 none, 1 precharge-all, 2 extended mode set, 3 mode set |
| status_o | output | 3 | 0 idle, 1 resetting, 2 in scan, 3 re-initializing, 4 ready |

## Verification
The bench measures each interval exactly: the CKE lead before each RES rise, the CLK_WAIT settle, the TSN_WAIT gap after scan exit and the command spacing. An off-by-one counter shows up as a mismatch of one cycle. It counts microsecond ticks while the device is in reset, so a design that releases RES early, or that counts ticks before the resetting state, is caught. It sends scan requests during the reset and exit-wait phases, where a design that did not gate them would raise SEN. A scoreboard checks the order and the exact cycle of the three restore commands, and a design that skipped re-initialization after scan, or that issued commands on the first power-up, leaves the queue unbalanced.

// File: rtl/mbs_pkg.sv
package mbs_pkg;

  typedef enum logic [3:0] {
    S_PWR, S_RLOW, S_CKSU, S_RHI, S_IDLE, S_READY,
    S_SCAN, S_XWAIT, S_CPRE, S_CEMRS, S_CMRS
  } seq_st_t;

  typedef enum logic [1:0] {
    OP_NOP  = 2'd0,
    OP_PRE  = 2'd1,
    OP_EMRS = 2'd2,
    OP_MRS  = 2'd3
  } mem_op_t;

  typedef enum logic [2:0] {
    STAT_IDLE   = 3'd0,
    STAT_RESET  = 3'd1,
    STAT_SCAN   = 3'd2,
    STAT_REINIT = 3'd3,
    STAT_READY  = 3'd4
  } seq_stat_t;

endpackage

// File: rtl/mbs_wait_cnt.sv
module mbs_wait_cnt #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr,
  input  logic         en,
  output logic [W-1:0] cnt_o
);
  // saturating up-counter, cleared whenever its owner changes state
  always_ff @(posedge clk) begin
    if (rst || clr)
      cnt_o <= '0;
    else if (en && (cnt_o != {W{1'b1}}))
      cnt_o <= cnt_o + 1'b1;
  end
endmodule

// File: rtl/mbs_sequencer.sv
module mbs_sequencer #(
  parameter int US_WAIT   = 200,
  parameter int CLK_WAIT  = 700,
  parameter int TSN_WAIT  = 20,
  parameter int CMD_GAP   = 4,
  parameter int CKE_SETUP = 3
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       supply_ok,
  input  logic       standalone,
  input  logic       scan_req,
  input  logic       scan_done,
  input  logic       us_tick,
  output logic       res_o,
  output logic       cke_o,
  output logic       sen_o,
  output logic       cmd_vld_o,
  output logic [1:0] cmd_op_o,
  output logic [2:0] status_o
);
  import mbs_pkg::*;

  localparam int MAX_A  = (CLK_WAIT > TSN_WAIT) ? CLK_WAIT : TSN_WAIT;
  localparam int MAX_B  = (CMD_GAP > CKE_SETUP) ? CMD_GAP : CKE_SETUP;
  localparam int MAX_C  = (MAX_A > MAX_B) ? MAX_A : MAX_B;
  localparam int CNT_W  = $clog2(MAX_C + 1);
  localparam int TICK_W = $clog2(US_WAIT + 1);

  seq_st_t           state_q, state_d;
  logic              entering;
  logic [CNT_W-1:0]  cyc_cnt;
  logic [CNT_W-1:0]  cyc_lim;
  logic              cyc_done;
  logic [TICK_W-1:0] tick_cnt;
  logic              reinit_q;

  assign entering = (state_d != state_q);

  mbs_wait_cnt #(.W(CNT_W)) i_cyc_cnt (
    .clk   (clk),
    .rst   (rst),
    .clr   (entering),
    .en    (1'b1),
    .cnt_o (cyc_cnt)
  );

  mbs_wait_cnt #(.W(TICK_W)) i_tick_cnt (
    .clk   (clk),
    .rst   (rst),
    .clr   (entering),
    .en    (us_tick && (state_q == S_RLOW)),
    .cnt_o (tick_cnt)
  );

  always_comb begin
    case (state_q)
      S_CKSU:                   cyc_lim = CNT_W'(CKE_SETUP - 1);
      S_RHI:                    cyc_lim = CNT_W'(CLK_WAIT - 1);
      S_XWAIT:                  cyc_lim = CNT_W'(TSN_WAIT - 1);
      S_CPRE, S_CEMRS, S_CMRS:  cyc_lim = CNT_W'(CMD_GAP - 1);
      default:                  cyc_lim = '0;
    endcase
  end
  assign cyc_done = (cyc_cnt == cyc_lim);

  always_comb begin
    state_d = state_q;
    case (state_q)
      S_PWR:   if (supply_ok) state_d = standalone ? S_IDLE : S_RLOW;
      S_RLOW:  if (tick_cnt >= TICK_W'(US_WAIT)) state_d = S_CKSU;
      S_CKSU:  if (cyc_done) state_d = S_RHI;
      S_RHI:   if (cyc_done) state_d = reinit_q ? S_CPRE : S_READY;
      S_IDLE,
      S_READY: if (scan_req) state_d = S_SCAN;
      S_SCAN:  if (scan_done) state_d = S_XWAIT;
      S_XWAIT: if (cyc_done) state_d = S_CKSU;
      S_CPRE:  if (cyc_done) state_d = S_CEMRS;
      S_CEMRS: if (cyc_done) state_d = S_CMRS;
      S_CMRS:  if (cyc_done) state_d = S_READY;
      default: state_d = S_PWR;
    endcase
  end

  function automatic logic res_high(input seq_st_t s);
    return (s == S_RHI) || (s == S_CPRE) || (s == S_CEMRS) ||
           (s == S_CMRS) || (s == S_READY);
  endfunction

  function automatic logic is_cmd(input seq_st_t s);
    return (s == S_CPRE) || (s == S_CEMRS) || (s == S_CMRS);
  endfunction

  function automatic mem_op_t op_of(input seq_st_t s);
    case (s)
      S_CPRE:  return OP_PRE;
      S_CEMRS: return OP_EMRS;
      S_CMRS:  return OP_MRS;
      default: return OP_NOP;
    endcase
  endfunction

  function automatic seq_stat_t stat_of(input seq_st_t s, input logic rein);
    case (s)
      S_RLOW:                          return STAT_RESET;
      S_CKSU, S_RHI:                   return rein ? STAT_REINIT : STAT_RESET;
      S_SCAN:                          return STAT_SCAN;
      S_XWAIT, S_CPRE, S_CEMRS, S_CMRS: return STAT_REINIT;
      S_READY:                         return STAT_READY;
      default:                         return STAT_IDLE;
    endcase
  endfunction

  // all device-facing levels come straight from flops, updated with the state
  always_ff @(posedge clk) begin
    if (rst) begin
      state_q   <= S_PWR;
      reinit_q  <= 1'b0;
      res_o     <= 1'b0;
      cke_o     <= 1'b0;
      sen_o     <= 1'b0;
      cmd_vld_o <= 1'b0;
      cmd_op_o  <= OP_NOP;
      status_o  <= STAT_IDLE;
    end else begin
      state_q <= state_d;
      if (state_q == S_SCAN && state_d == S_XWAIT)
        reinit_q <= 1'b1;
      else if (state_d == S_READY)
        reinit_q <= 1'b0;
      res_o     <= res_high(state_d);
      cke_o     <= res_high(state_d) || (state_d == S_CKSU);
      sen_o     <= (state_d == S_SCAN);
      cmd_vld_o <= is_cmd(state_d) && entering;
      cmd_op_o  <= (is_cmd(state_d) && entering) ? op_of(state_d) : OP_NOP;
      status_o  <= stat_of(state_d, reinit_q || (state_q == S_SCAN));
    end
  end

endmodule

// File: rtl/mbs_sequencer_chk.sv
module mbs_sequencer_chk (
  input logic       clk,
  input logic       rst,
  input logic       supply_ok,
  input logic       standalone,
  input logic       scan_req,
  input logic       scan_done,
  input logic       us_tick,
  input logic       res_o,
  input logic       cke_o,
  input logic       sen_o,
  input logic       cmd_vld_o,
  input logic [1:0] cmd_op_o,
  input logic [2:0] status_o
);
  assert_reset_quiet_R1: assert property (@(posedge clk)
    $past(rst) |-> (!res_o && !cke_o && !sen_o && !cmd_vld_o));

  assert_cke_lead_R3: assert property (@(posedge clk) disable iff (rst)
    $rose(res_o) |-> (cke_o && $past(cke_o)));

  assert_cke_hold_R3: assert property (@(posedge clk) disable iff (rst)
    res_o |-> cke_o);

  assert_scan_res_low_R5: assert property (@(posedge clk) disable iff (rst)
    sen_o |-> !res_o);

  assert_exit_res_low_R7: assert property (@(posedge clk) disable iff (rst)
    $fell(sen_o) |-> !res_o);

  assert_cmd_pins_R8: assert property (@(posedge clk) disable iff (rst)
    cmd_vld_o |-> (res_o && cke_o && !sen_o && cmd_op_o != 2'd0));

  assert_cmd_single_R8: assert property (@(posedge clk) disable iff (rst)
    cmd_vld_o |=> !cmd_vld_o);

  assert_no_op_idle_R8: assert property (@(posedge clk) disable iff (rst)
    !cmd_vld_o |-> (cmd_op_o == 2'd0));

  assert_cmd_reinit_R9: assert property (@(posedge clk) disable iff (rst)
    cmd_vld_o |-> (status_o == 3'd3));

  assert_status_range_R11: assert property (@(posedge clk) disable iff (rst)
    status_o <= 3'd4);
endmodule

bind mbs_sequencer mbs_sequencer_chk i_chk (.*);

// File: tb/test_mbs_sequencer.sv
module test_mbs_sequencer;
  localparam int US_WAIT   = 200;
  localparam int CLK_WAIT  = 700;
  localparam int TSN_WAIT  = 20;
  localparam int CMD_GAP   = 4;
  localparam int CKE_SETUP = 3;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       supply_ok = 1'b0, standalone = 1'b0;
  logic       scan_req = 1'b0, scan_done = 1'b0, us_tick = 1'b0;
  logic       res_o, cke_o, sen_o, cmd_vld_o;
  logic [1:0] cmd_op_o;
  logic [2:0] status_o;

  int total = 0, bad = 0, cyc = 0, ticks = 0;
  bit tick_en = 1'b0;

  typedef struct { logic [1:0] op; int at; } exp_t;
  exp_t sb[$];

  always #2.5 clk = ~clk;

  mbs_sequencer #(.US_WAIT(US_WAIT), .CLK_WAIT(CLK_WAIT), .TSN_WAIT(TSN_WAIT),
                  .CMD_GAP(CMD_GAP), .CKE_SETUP(CKE_SETUP)) i_mbs_sequencer (
    .clk(clk), .rst(rst), .supply_ok(supply_ok), .standalone(standalone),
    .scan_req(scan_req), .scan_done(scan_done), .us_tick(us_tick),
    .res_o(res_o), .cke_o(cke_o), .sen_o(sen_o), .cmd_vld_o(cmd_vld_o),
    .cmd_op_o(cmd_op_o), .status_o(status_o));

  // R2 reference: ticks seen while the device is held in reset
  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (us_tick && status_o == 3'd1 && !cke_o) ticks <= ticks + 1;
  end

  always @(negedge clk) us_tick <= tick_en && (cyc % 5 == 0);

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic push_cmds(input int first);
    exp_t e;
    for (int k = 0; k < 3; k++) begin
      e.op = 2'(k + 1);
      e.at = first + k * CMD_GAP;
      sb.push_back(e);
    end
  endtask

  // scoreboard monitor (R8)
  always @(negedge clk) begin
    if (!rst && cmd_vld_o) begin
      if (sb.size() == 0) chk(1'b0, "R8 unexpected cmd", int'(cmd_op_o), 0);
      else begin
        exp_t e;
        e = sb.pop_front();
        chk(cmd_op_o == e.op, "R8 opcode", int'(cmd_op_o), int'(e.op));
        chk(cyc == e.at, "R8 cmd cycle", cyc, e.at);
      end
    end
  end

  task automatic pulse(ref logic s);
    @(negedge clk) s = 1'b1;
    @(negedge clk) s = 1'b0;
  endtask

  // wait at negedges until the given output takes the given value; returns cycle
  task automatic wait_res(input logic v, output int at);
    at = -1;
    for (int n = 0; n < 5000; n++) begin
      @(negedge clk);
      if (res_o === v) begin at = cyc; break; end
    end
    chk(at >= 0, "timeout res", 0, 1);
  endtask

  task automatic wait_cke(output int at);
    at = -1;
    for (int n = 0; n < 5000; n++) begin
      @(negedge clk);
      if (cke_o === 1'b1) begin at = cyc; break; end
    end
    chk(at >= 0, "timeout cke", 0, 1);
  endtask

  task automatic wait_stat(input logic [2:0] v, output int at);
    at = -1;
    for (int n = 0; n < 5000; n++) begin
      @(negedge clk);
      if (status_o === v) begin at = cyc; break; end
    end
    chk(at >= 0, "timeout status", int'(status_o), int'(v));
  endtask

  task automatic scan_round(input string tag);
    int f, r, rd;
    pulse(scan_req);
    chk(sen_o && !res_o, "R5 scan entry sen/res", int'({sen_o, res_o}), 2);
    chk(status_o == 3'd2, "R5 status in-scan", int'(status_o), 2);
    repeat (5) @(negedge clk);
    pulse(scan_done);
    f = cyc;
    chk(!sen_o, "R7 sen low after done", int'(sen_o), 0);
    chk(status_o == 3'd3, "R9 status reinit", int'(status_o), 3);
    push_cmds(f + TSN_WAIT + CKE_SETUP + CLK_WAIT);
    pulse(scan_req);
    chk(!sen_o && status_o == 3'd3, "R6 scan_req in exit wait", int'(sen_o), 0);
    wait_res(1'b1, r);
    chk(r == f + TSN_WAIT + CKE_SETUP, "R7 res rise after exit", r - f,
        TSN_WAIT + CKE_SETUP);
    wait_stat(3'd4, rd);
    chk(rd == r + CLK_WAIT + 3 * CMD_GAP, "R9 ready after cmds", rd - r,
        CLK_WAIT + 3 * CMD_GAP);
    chk(sb.size() == 0, "R8 all cmds seen", sb.size(), 0);
    $display("round %s done", tag);
  endtask

  initial begin
    int c, r, rd;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(!res_o && !cke_o && !sen_o && !cmd_vld_o && cmd_op_o == 2'd0, "R1 reset outputs",
        int'({res_o, cke_o, sen_o, cmd_vld_o}), 0);
    chk(status_o == 3'd0, "R1 reset status", int'(status_o), 0);

    // normal power-up path
    tick_en = 1'b1;
    supply_ok = 1'b1;
    @(negedge clk);
    chk(status_o == 3'd1, "R11 resetting code", int'(status_o), 1);
    repeat (40) @(negedge clk);
    pulse(scan_req);
    chk(!sen_o && status_o == 3'd1, "R6 scan_req in reset", int'(sen_o), 0);
    wait_cke(c);
    chk(ticks >= US_WAIT, "R2 reset low ticks", ticks, US_WAIT);
    chk(!res_o, "R2 res still low at cke rise", int'(res_o), 0);
    wait_res(1'b1, r);
    chk(r - c == CKE_SETUP, "R3 cke lead", r - c, CKE_SETUP);
    wait_stat(3'd4, rd);
    chk(rd - r == CLK_WAIT, "R4 settle to ready", rd - r, CLK_WAIT);
    chk(cke_o && res_o, "R3 cke held with res", int'(cke_o), 1);
    chk(sb.size() == 0 && !cmd_vld_o, "R4 no cmd on first init", 0, 0);

    scan_round("normal");

    // stand-alone path
    @(negedge clk) rst = 1'b1;
    supply_ok = 1'b0;
    standalone = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    supply_ok = 1'b1;
    repeat (30) @(negedge clk);
    chk(status_o == 3'd0 && !res_o && !cke_o, "R10 standalone idle", int'(status_o), 0);
    scan_round("standalone");

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    chk(1'b0, "watchdog", cyc, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule